// File: doc/BRIEF.md
# Colour standard search sequencer

This block decides which colour television standard an incoming video signal carries. Software supplies a table of eight 3-bit standard codes. The block works through the table from the first entry, one trial per entry. During each trial the block shows the code under test to an external detector, and the detector answers pass or fail once per field. A terminator code in the table ends the list early. When the list has been walked, exactly one entry must have passed. That entry then goes through a confirmation phase: a programmable number of consecutive fields must all pass before the identified flag goes high and the standard code is published.

Any other outcome sends the sequencer back to the first table entry. This covers no passing entry, more than one passing entry, and a failed confirmation field. Once a standard is identified, the block keeps checking it, and it drops the result after three failing fields in a row. Everything advances only on a one-cycle field strobe.

Code meanings used throughout: 000 PAL B/D/G/H/I, 001 SECAM, 010 NTSC M, 011 PAL M, 100 PAL N, 101 NTSC 4.43. Codes 110 and 111 mean no standard.

Top module: `std_search_seq`

## Requirements
- R1: After reset the identified flag is 0, the reported standard is 111 and the code under trial is table entry 0.
- R2: Table entry i sits in bits [3i+2:3i] of the table input. Entries are tried in ascending order from entry 0. Each trial spans two field strobes, and the code under trial is held across both of them. The pass/fail input is sampled only on the second strobe of a trial.
- R3: An entry of 110 or 111 ends the list, and neither it nor any later entry is tried. When entry 0 is a terminator, no trial runs and the flag never rises. When there is no terminator, entry 7 is the last one tried.
- R4: If exactly one entry passed when the list ends, confirmation starts, and the code under trial becomes that entry's code. Two table entries with the same code count as two separate entries.
- R5: If zero entries or two or more entries passed, the search restarts at entry 0 and the flag stays 0.
- R6: The confirmation code maps 000 to 1 field, 001 to 3 fields, 010 to 7 fields, and every other value to 10 fields. After that many consecutive passing field strobes, the flag rises and the reported standard equals the confirmed code. The flag rises on the last of those strobes and not before it.
- R7: A failing field during confirmation restarts the search at entry 0 with the flag still 0.
- R8: While identified, three consecutive failing fields clear the flag, set the reported standard to 111 and restart the search at entry 0. A passing field resets this failure count.
- R9: With no field strobe, the pass/fail input has no effect and the sequencer state does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fieldStb | input | 1 | One-cycle strobe, once per video field |
| trialPass | input | 1 | Detector verdict for the code under trial, valid with fieldStb |
| stdTable | input | 24 | Eight 3-bit standard codes, entry i at bits [3i+2:3i] |
| confCode | input | 3 | Confirmation field-count code |
| trialCode | output | 3 | Code currently being tried or confirmed |
| identified | output | 1 | High once a standard is confirmed |
| stdCode | output | 3 | Confirmed standard code, 111 when none |

## Verification
The bench sweeps every confirmation code against each entry position of the default table. It checks that the flag rises exactly on the last required field. A sequencer that counts one field too few or too many, or that lets codes above 011 fall to a short count, fails this sweep. Ambiguous and empty results, duplicate codes, a full table without terminators and a terminator at entry 0 are each driven. A design that failed to restart, that tried past a terminator, or that merged duplicates would show the wrong trial code or a spurious flag. The loss window is probed with two failures, a pass and two more failures, so that a failure counter that is not cleared by a passing field is caught.

// File: rtl/std_search_pkg.sv
package std_search_pkg;

  localparam int STD_W = 3;
  typedef logic [STD_W-1:0] stdCode_t;
  localparam stdCode_t NO_STD = 3'b111;

  typedef enum logic [1:0] {
    S_SEARCH  = 2'd0,
    S_CONFIRM = 2'd1,
    S_LOCKED  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic clrSearch;
    logic nextPhase;
    logic nextEntry;
    logic takePass;
    logic startConf;
    logic nextConf;
    logic lockStd;
    logic nextLoss;
    logic clrLoss;
    logic showCand;
  } searchStb_t;

  function automatic logic isNoStd(input stdCode_t code);
    return (code == 3'b110) || (code == 3'b111);
  endfunction

  function automatic logic [3:0] confFields(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd3;
      3'd2:    return 4'd7;
      default: return 4'd10;
    endcase
  endfunction

endpackage

// File: rtl/std_search_dp.sv
module std_search_dp
  import std_search_pkg::*;
#(
  parameter int NUM_ENTRIES  = 8,
  parameter int TRIAL_FIELDS = 2,
  parameter int LOSS_FIELDS  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_ENTRIES*STD_W-1:0] stdTable,
  input  logic [2:0]                   confCode,
  input  searchStb_t                   stb,
  output logic                         curTerm,
  output logic                         lastField,
  output logic                         lastEntry,
  output logic [1:0]                   passCnt,
  output logic                         confDone,
  output logic                         lossDone,
  output stdCode_t                     trialCode,
  output stdCode_t                     stdCode
);

  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int PH_W   = (TRIAL_FIELDS > 1) ? $clog2(TRIAL_FIELDS) : 1;
  localparam int LOSS_W = (LOSS_FIELDS > 1) ? $clog2(LOSS_FIELDS) : 1;

  stdCode_t           entryArr [NUM_ENTRIES];
  logic [IDX_W-1:0]   idx, nextIdx;
  logic [PH_W-1:0]    phase;
  logic [3:0]         confCnt;
  logic [LOSS_W-1:0]  lossCnt;
  stdCode_t           candCode;
  stdCode_t           curCode;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gUnpack
    assign entryArr[g] = stdTable[g*STD_W +: STD_W];
  end

  assign curCode   = entryArr[idx];
  assign nextIdx   = idx + 1'b1;
  assign curTerm   = isNoStd(curCode);
  assign lastField = (phase == PH_W'(TRIAL_FIELDS - 1));
  assign lastEntry = (idx == IDX_W'(NUM_ENTRIES - 1)) || isNoStd(entryArr[nextIdx]);
  assign confDone  = (confCnt == (confFields(confCode) - 4'd1));
  assign lossDone  = (lossCnt == LOSS_W'(LOSS_FIELDS - 1));
  assign trialCode = stb.showCand ? candCode : curCode;

  // table walk: entry index, field phase inside a trial
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx   <= '0;
      phase <= '0;
    end else if (stb.clrSearch) begin
      idx   <= '0;
      phase <= '0;
    end else if (stb.nextEntry) begin
      idx   <= nextIdx;
      phase <= '0;
    end else if (stb.nextPhase) begin
      phase <= phase + 1'b1;
    end
  end

  // passing-entry tally and candidate capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passCnt  <= '0;
      candCode <= NO_STD;
    end else if (stb.clrSearch) begin
      passCnt  <= '0;
    end else if (stb.takePass) begin
      passCnt  <= (passCnt == 2'd2) ? 2'd2 : passCnt + 2'd1;
      candCode <= curCode;
    end
  end

  // confirmation and loss counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      confCnt <= '0;
      lossCnt <= '0;
    end else begin
      if (stb.startConf || stb.clrSearch) confCnt <= '0;
      else if (stb.nextConf)              confCnt <= confCnt + 4'd1;
      if (stb.startConf || stb.clrLoss || stb.lockStd || stb.clrSearch) lossCnt <= '0;
      else if (stb.nextLoss)                                            lossCnt <= lossCnt + 1'b1;
    end
  end

  // published standard
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             stdCode <= NO_STD;
    else if (stb.clrSearch) stdCode <= NO_STD;
    else if (stb.lockStd)   stdCode <= candCode;
  end

  AST_CAND_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stb.showCand |-> !isNoStd(candCode)); // R4

  AST_CONF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    confCnt < confFields(confCode) || $changed(confCode) || !stb.showCand); // R6

endmodule

// File: rtl/std_search_ctrl.sv
module std_search_ctrl
  import std_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fieldStb,
  input  logic       trialPass,
  input  logic       curTerm,
  input  logic       lastField,
  input  logic       lastEntry,
  input  logic [1:0] passCnt,
  input  logic       confDone,
  input  logic       lossDone,
  output searchStb_t stb,
  output logic       identified
);

  seqState_t state, stateNext;
  logic      singlePass;

  assign singlePass = (passCnt == 2'd1 && !trialPass) || (passCnt == 2'd0 && trialPass);
  assign identified = (state == S_LOCKED);

  always_comb begin
    stb          = '0;
    stateNext    = state;
    stb.showCand = (state != S_SEARCH);
    unique case (state)
      S_SEARCH: begin
        if (fieldStb && !curTerm) begin
          if (!lastField) begin
            stb.nextPhase = 1'b1;
          end else if (!lastEntry) begin
            stb.nextEntry = 1'b1;
            stb.takePass  = trialPass;
          end else if (singlePass) begin
            stb.takePass  = trialPass;
            stb.startConf = 1'b1;
            stateNext     = S_CONFIRM;
          end else begin
            stb.clrSearch = 1'b1;
          end
        end
      end
      S_CONFIRM: begin
        if (fieldStb) begin
          if (!trialPass) begin
            stb.clrSearch = 1'b1;
            stateNext     = S_SEARCH;
          end else if (confDone) begin
            stb.lockStd = 1'b1;
            stateNext   = S_LOCKED;
          end else begin
            stb.nextConf = 1'b1;
          end
        end
      end
      S_LOCKED: begin
        if (fieldStb) begin
          if (trialPass) begin
            stb.clrLoss = 1'b1;
          end else if (lossDone) begin
            stb.clrSearch = 1'b1;
            stateNext     = S_SEARCH;
          end else begin
            stb.nextLoss = 1'b1;
          end
        end
      end
      default: begin
        stb.clrSearch = 1'b1;
        stateNext     = S_SEARCH;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_SEARCH;
    else       state <= stateNext;
  end

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fieldStb |=> state == $past(state)); // R9

  AST_LOCK_PATH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(identified) |-> ($past(state) == S_CONFIRM && $past(trialPass) && $past(fieldStb))); // R6

endmodule

// File: rtl/std_search_seq.sv
module std_search_seq
  import std_search_pkg::*;
#(
  parameter int NUM_ENTRIES  = 8,
  parameter int TRIAL_FIELDS = 2,
  parameter int LOSS_FIELDS  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fieldStb,
  input  logic                         trialPass,
  input  logic [NUM_ENTRIES*STD_W-1:0] stdTable,
  input  logic [2:0]                   confCode,
  output logic [STD_W-1:0]             trialCode,
  output logic                         identified,
  output logic [STD_W-1:0]             stdCode
);

  searchStb_t stb;
  logic       curTerm, lastField, lastEntry, confDone, lossDone;
  logic [1:0] passCnt;

  std_search_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fieldStb   (fieldStb),
    .trialPass  (trialPass),
    .curTerm    (curTerm),
    .lastField  (lastField),
    .lastEntry  (lastEntry),
    .passCnt    (passCnt),
    .confDone   (confDone),
    .lossDone   (lossDone),
    .stb        (stb),
    .identified (identified)
  );

  std_search_dp #(
    .NUM_ENTRIES  (NUM_ENTRIES),
    .TRIAL_FIELDS (TRIAL_FIELDS),
    .LOSS_FIELDS  (LOSS_FIELDS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stdTable  (stdTable),
    .confCode  (confCode),
    .stb       (stb),
    .curTerm   (curTerm),
    .lastField (lastField),
    .lastEntry (lastEntry),
    .passCnt   (passCnt),
    .confDone  (confDone),
    .lossDone  (lossDone),
    .trialCode (trialCode),
    .stdCode   (stdCode)
  );

  AST_STD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !identified |-> stdCode == NO_STD); // R8

  AST_STD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    identified |-> !isNoStd(stdCode)); // R6

endmodule

// File: tb/tb_std_search_seq.sv
`timescale 1ns/1ps
module tb_std_search_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fieldStb = 1'b0;
  logic        trialPass = 1'b0;
  logic [23:0] stdTable;
  logic [2:0]  confCode = 3'd1;
  logic [2:0]  trialCode;
  logic        identified;
  logic [2:0]  stdCode;

  logic [2:0]  tbl [8];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  std_search_seq dut (
    .clk(clk), .rstN(rstN), .fieldStb(fieldStb), .trialPass(trialPass),
    .stdTable(stdTable), .confCode(confCode), .trialCode(trialCode),
    .identified(identified), .stdCode(stdCode)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int needOf(input int c);
    if (c == 0) return 1;
    if (c == 1) return 3;
    if (c == 2) return 7;
    return 10;
  endfunction

  function automatic bit isTerm(input logic [2:0] c);
    return c >= 3'd6;
  endfunction

  task automatic loadTable(input logic [2:0] e0, e1, e2, e3, e4, e5, e6, e7);
    tbl[0] = e0; tbl[1] = e1; tbl[2] = e2; tbl[3] = e3;
    tbl[4] = e4; tbl[5] = e5; tbl[6] = e6; tbl[7] = e7;
    for (int i = 0; i < 8; i++) stdTable[i*3 +: 3] = tbl[i];
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    fieldStb = 1'b0;
    trialPass = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic field(input bit p);
    @(negedge clk);
    fieldStb = 1'b1;
    trialPass = p;
    @(negedge clk);
    fieldStb = 1'b0;
    trialPass = 1'b0;
  endtask

  // walk the list, passing the entries set in mask; returns pass count and last passing index
  task automatic runSearch(input logic [7:0] mask, output int cnt, output int cand);
    cnt = 0;
    cand = 0;
    for (int i = 0; i < 8; i++) begin
      if (isTerm(tbl[i])) break;
      checkEq("R2", "code under trial", trialCode, tbl[i]);
      field(1'b0);
      checkEq("R2", "code held mid trial", trialCode, tbl[i]);
      field(mask[i]);
      if (mask[i]) begin
        cnt++;
        cand = i;
      end
    end
    if (cnt == 1) begin
      checkEq("R4", "candidate shown", trialCode, tbl[cand]);
    end else begin
      checkEq("R5", "restart at entry 0", trialCode, tbl[0]);
      checkEq("R5", "flag low after bad search", identified, 0);
    end
  endtask

  initial begin
    int cnt, cand, need;
    loadTable(3'b000, 3'b001, 3'b010, 3'b111, 3'b001, 3'b001, 3'b111, 3'b111);
    doReset();
    checkEq("R1", "flag at reset", identified, 0);
    checkEq("R1", "std at reset", stdCode, 7);
    checkEq("R1", "trial at reset", trialCode, 0);

    // R9: pass input toggling without strobes moves nothing
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      trialPass = k[0];
    end
    @(negedge clk);
    trialPass = 1'b0;
    checkEq("R9", "no strobe no move", trialCode, tbl[0]);
    field(1'b1);
    checkEq("R9", "first strobe stays on entry", trialCode, tbl[0]);
    field(1'b0);
    checkEq("R2", "second strobe advances", trialCode, tbl[1]);

    // R6 / R8 sweep: every confirmation code, every default-table position
    for (int c = 0; c < 8; c++) begin
      for (int pos = 0; pos < 3; pos++) begin
        confCode = c[2:0];
        doReset();
        runSearch(8'(1 << pos), cnt, cand);
        need = needOf(c);
        for (int k = 1; k <= need; k++) begin
          field(1'b1);
          if (k < need) checkEq("R6", "flag early", identified, 0);
        end
        checkEq("R6", "flag after confirmation", identified, 1);
        checkEq("R6", "std code", stdCode, tbl[pos]);
        field(1'b0);
        field(1'b0);
        checkEq("R8", "flag after two failures", identified, 1);
        field(1'b1);
        field(1'b0);
        field(1'b0);
        checkEq("R8", "pass resets loss count", identified, 1);
        field(1'b0);
        checkEq("R8", "flag after three failures", identified, 0);
        checkEq("R8", "std cleared", stdCode, 7);
        checkEq("R8", "search from top", trialCode, tbl[0]);
      end
    end

    // R5: ambiguous and empty searches, then a clean one from the top
    confCode = 3'd0;
    doReset();
    runSearch(8'b0000_0011, cnt, cand);
    runSearch(8'b0000_0000, cnt, cand);
    runSearch(8'b0000_0100, cnt, cand);
    field(1'b1);
    checkEq("R6", "single field confirm", identified, 1);
    checkEq("R6", "std NTSC M", stdCode, 2);

    // R4: duplicate codes are separate entries
    loadTable(3'b010, 3'b010, 3'b110, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000);
    doReset();
    runSearch(8'b0000_0011, cnt, cand);
    checkEq("R4", "duplicates both passing", identified, 0);
    runSearch(8'b0000_0010, cnt, cand);
    checkEq("R4", "duplicate single pass", trialCode, 2);

    // R3: full table without terminator, last entry passes
    loadTable(3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b000, 3'b001);
    confCode = 3'd0;
    doReset();
    runSearch(8'b1000_0000, cnt, cand);
    checkEq("R3", "entry 7 tried", cnt, 1);
    field(1'b1);
    checkEq("R3", "entry 7 identified", stdCode, 1);

    // R3: terminator in the middle ends the list
    loadTable(3'b011, 3'b110, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000);
    doReset();
    field(1'b0);
    field(1'b1);
    checkEq("R3", "list ends at terminator", trialCode, 3);

    // R3: terminator at entry 0 means no trial at all
    loadTable(3'b110, 3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b000);
    doReset();
    for (int k = 0; k < 20; k++) field(1'b1);
    checkEq("R3", "no trial with empty list", trialCode, 6);
    checkEq("R3", "no flag with empty list", identified, 0);

    // R7: confirmation failure restarts
    loadTable(3'b000, 3'b001, 3'b010, 3'b111, 3'b001, 3'b001, 3'b111, 3'b111);
    confCode = 3'd1;
    doReset();
    runSearch(8'b0000_0010, cnt, cand);
    field(1'b1);
    field(1'b0);
    checkEq("R7", "restart after confirm fail", trialCode, tbl[0]);
    checkEq("R7", "flag low after confirm fail", identified, 0);
    field(1'b1);
    field(1'b1);
    checkEq("R7", "fresh search still on entry", trialCode, tbl[1]);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule